// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Decoder

This block sits on the slave side of a two-wire serial bus that has a clock line and a data line. It samples both lines with the system clock and recognises the bus start and stop conditions. It shifts in bytes most significant bit first and acknowledges the bytes it accepts by pulling the data line low through an open-drain enable. The first byte after a start carries a fixed device-type nibble and a strapped 4-bit address. The second byte is an instruction that selects an operation, one of two potentiometers and one of four stored registers.

Register-transfer commands complete at the stop that follows the instruction. Write commands carry a third data byte and complete once that byte has been acknowledged. Each completed command is handed to the register bank as a one-cycle strobe together with its fields. An increment/decrement instruction switches the block out of byte framing. From then on, every clock-line pulse is turned into a one-step wiper move, and the level of the data line gives its direction. This mode lasts until the next start or stop.

Top module: `tw_pot_cmd`

## Requirements
- R1: While reset is held, and after it is released, `sda_oe_o`, `cmd_valid_o` and `step_valid_o` are low.
- R2: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Data bits are sampled on clock rising edges, most significant bit first.
- R3: The address byte is accepted only when bits [7:4] equal 4'b0101 and bits [3:0] equal `dev_addr_i`. An accepted byte is acknowledged by holding `sda_oe_o` high through the ninth clock pulse. On a mismatch there is no acknowledge and no strobe, and the bus is ignored until the next start.
- R4: The instruction byte is decoded as opcode = bits [7:4], reserved bit 3 (must be 0), pot select = bit 2 and register select = bits [1:0]. After a matching address, the instruction byte is always acknowledged.
- R5: Opcodes 1101, 1110, 0001 and 1000 produce `cmd_op_o` codes 0, 1, 2 and 3 respectively. Each gives one `cmd_valid_o` pulse, carrying that instruction's pot and register selects, at the stop that follows the acknowledged instruction. A start that arrives first discards the command.
- R6: Opcodes 1010 (write wiper, code 4) and 1100 (write data register, code 5) take a third byte. That byte is acknowledged, and `cmd_valid_o` pulses at the end of its acknowledge slot with `cmd_data_o` equal to the byte. A stop that arrives before then discards the command.
- R7: After the acknowledge slot of opcode 0010 ends, each later clock pulse (rise then fall) gives one `step_valid_o` pulse. `step_up_o` equals the data-line level at that rise, where 1 means toward the high end. A start or stop ends the mode, and the pulse that carries a start or stop produces no step.
- R8: Unlisted opcodes, and instructions with bit 3 set, are acknowledged and then produce no strobe. No later byte is acknowledged before the next start.
- R9: Bytes beyond a command's length are not acknowledged and do not change the strobe already due.
- R10: `cmd_valid_o` and `step_valid_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_addr_i | input | 4 | Strapped device address |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 3 | Command code (see R5, R6) |
| cmd_pot_o | output | 1 | Potentiometer select of the command |
| cmd_reg_o | output | 2 | Register select of the command |
| cmd_data_o | output | 8 | Data byte of write commands |
| step_valid_o | output | 1 | One-cycle wiper step strobe |
| step_up_o | output | 1 | Step direction, 1 toward the high end |

## Verification
The hardest situations to reach are the edges of a command's lifetime: a pending transfer that a repeated start must cancel, a write that a stop must cut short, and a stepping session that a start or stop ends during a clock pulse that must not count. The bench drives the bus with an open-drain model and composes these endings on purpose. It also sweeps every address against several straps and every opcode with both pot selects. For each case it computes the expected acknowledge, strobe fields and step counts from the opcode table.

// File: rtl/tw_pot_pkg.sv
package tw_pot_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [2:0] {
    CMD_DR_TO_WCR     = 3'd0,
    CMD_WCR_TO_DR     = 3'd1,
    CMD_ALL_DR_TO_WCR = 3'd2,
    CMD_ALL_WCR_TO_DR = 3'd3,
    CMD_WRITE_WCR     = 3'd4,
    CMD_WRITE_DR      = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {K_NONE, K_TWO, K_THREE, K_STEP} kind_e;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_STEP} state_e;

  typedef struct packed {
    kind_e kind;
    cmd_e  cmd;
  } dec_t;

  function automatic dec_t decode_instr(input logic [7:0] b);
    dec_t d;
    d.kind = K_NONE;
    d.cmd  = CMD_DR_TO_WCR;
    if (!b[3]) begin
      case (b[7:4])
        4'b1101: begin d.kind = K_TWO;   d.cmd = CMD_DR_TO_WCR;     end
        4'b1110: begin d.kind = K_TWO;   d.cmd = CMD_WCR_TO_DR;     end
        4'b0001: begin d.kind = K_TWO;   d.cmd = CMD_ALL_DR_TO_WCR; end
        4'b1000: begin d.kind = K_TWO;   d.cmd = CMD_ALL_WCR_TO_DR; end
        4'b1010: begin d.kind = K_THREE; d.cmd = CMD_WRITE_WCR;     end
        4'b1100: begin d.kind = K_THREE; d.cmd = CMD_WRITE_DR;      end
        4'b0010: d.kind = K_STEP;
        default: d.kind = K_NONE;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/tw_pot_sync.sv
module tw_pot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edge while the clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_pot_framer.sv
module tw_pot_framer #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            frame_en_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_i,
  input  logic            ack_req_i,
  output logic [BITS-1:0] byte_o,
  output logic            byte_done_o,
  output logic            slot_end_o,
  output logic            sda_oe_o
);
  localparam int CNT_W = $clog2(BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  sh_q;

  assign byte_o      = sh_q;
  assign byte_done_o = frame_en_i & ~restart_i & scl_fall_i & (cnt_q == CNT_FULL);
  assign slot_end_o  = frame_en_i & ~restart_i & scl_fall_i & (cnt_q == CNT_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      sda_oe_o <= 1'b0;
    end else if (restart_i || !frame_en_i) begin
      cnt_q    <= '0;
      sda_oe_o <= 1'b0;
    end else if (scl_rise_i && cnt_q < CNT_FULL) begin
      sh_q  <= {sh_q[BITS-2:0], sda_i};
      cnt_q <= cnt_q + 1'b1;
    end else if (byte_done_o) begin
      cnt_q    <= CNT_ACK;
      sda_oe_o <= ack_req_i;
    end else if (slot_end_o) begin
      cnt_q    <= '0;
      sda_oe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_pot_ctrl.sv
module tw_pot_ctrl
  import tw_pot_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              byte_done_i,
  input  logic              slot_end_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              frame_en_o,
  output logic              ack_req_o,
  output logic              in_step_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic              cmd_pot_o,
  output logic [1:0]        cmd_reg_o,
  output logic [7:0]        cmd_data_o,
  output logic              step_valid_o,
  output logic              step_up_o
);
  state_e     state_q;
  dec_t       dec_q;
  logic       pot_q, pend_q, dir_q;
  logic [1:0] reg_q;
  logic       addr_hit;

  assign addr_hit   = (byte_i == {DEV_TYPE, dev_addr_i});
  assign frame_en_o = (state_q == S_ADDR) || (state_q == S_INSTR) || (state_q == S_DATA);
  assign in_step_o  = (state_q == S_STEP);

  always_comb begin
    case (state_q)
      S_ADDR:          ack_req_o = addr_hit;
      S_INSTR, S_DATA: ack_req_o = 1'b1;
      default:         ack_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      dec_q        <= '0;
      pot_q        <= 1'b0;
      reg_q        <= '0;
      pend_q       <= 1'b0;
      dir_q        <= 1'b0;
      cmd_valid_o  <= 1'b0;
      cmd_op_o     <= '0;
      cmd_pot_o    <= 1'b0;
      cmd_reg_o    <= '0;
      cmd_data_o   <= '0;
      step_valid_o <= 1'b0;
      step_up_o    <= 1'b0;
    end else begin
      cmd_valid_o  <= 1'b0;
      step_valid_o <= 1'b0;
      if (start_i) begin
        state_q <= S_ADDR;
        pend_q  <= 1'b0;
      end else if (stop_i) begin
        if (pend_q) begin
          cmd_valid_o <= 1'b1;
          cmd_op_o    <= dec_q.cmd;
          cmd_pot_o   <= pot_q;
          cmd_reg_o   <= reg_q;
        end
        pend_q  <= 1'b0;
        state_q <= S_IDLE;
      end else begin
        case (state_q)
          S_ADDR: begin
            if (byte_done_i && !addr_hit) state_q <= S_IDLE;
            else if (slot_end_i)          state_q <= S_INSTR;
          end
          S_INSTR: begin
            if (byte_done_i) begin
              dec_q <= decode_instr(byte_i);
              pot_q <= byte_i[2];
              reg_q <= byte_i[1:0];
            end else if (slot_end_i) begin
              case (dec_q.kind)
                K_TWO:   begin pend_q <= 1'b1; state_q <= S_IDLE; end
                K_THREE: state_q <= S_DATA;
                K_STEP:  state_q <= S_STEP;
                default: state_q <= S_IDLE;
              endcase
            end
          end
          S_DATA: begin
            if (byte_done_i) cmd_data_o <= byte_i;
            else if (slot_end_i) begin
              cmd_valid_o <= 1'b1;
              cmd_op_o    <= dec_q.cmd;
              cmd_pot_o   <= pot_q;
              cmd_reg_o   <= reg_q;
              state_q     <= S_IDLE;
            end
          end
          S_STEP: begin
            // direction taken at the rise, move issued at the fall
            if (scl_rise_i) dir_q <= sda_i;
            if (scl_fall_i) begin
              step_valid_o <= 1'b1;
              step_up_o    <= dir_q;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_pot_cmd.sv
module tw_pot_cmd #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic              cmd_pot_o,
  output logic [1:0]        cmd_reg_o,
  output logic [7:0]        cmd_data_o,
  output logic              step_valid_o,
  output logic              step_up_o
);
  localparam int BYTE_W = 8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic frame_en, ack_req, byte_done, slot_end, in_step;
  logic [BYTE_W-1:0] rx_byte;

  tw_pot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tw_pot_framer #(.BITS(BYTE_W)) u_framer (
    .clk_i, .rst_ni,
    .restart_i(start_det | stop_det), .frame_en_i(frame_en),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .ack_req_i(ack_req), .byte_o(rx_byte), .byte_done_o(byte_done),
    .slot_end_o(slot_end), .sda_oe_o
  );

  tw_pot_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i(start_det), .stop_i(stop_det),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .byte_done_i(byte_done), .slot_end_i(slot_end), .byte_i(rx_byte),
    .dev_addr_i, .frame_en_o(frame_en), .ack_req_o(ack_req), .in_step_o(in_step),
    .cmd_valid_o, .cmd_op_o, .cmd_pot_o, .cmd_reg_o, .cmd_data_o,
    .step_valid_o, .step_up_o
  );
endmodule

// File: rtl/tw_pot_cmd_chk.sv
module tw_pot_cmd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_fall_i,
  input logic       stop_det_i,
  input logic       in_step_i,
  input logic       sda_oe_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_op_o,
  input logic       step_valid_o
);
  p_cmd_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  p_step_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |=> !step_valid_o);
  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && step_valid_o));
  p_op_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_op_o <= 3'd5);
  p_ack_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));
  p_stop_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_det_i) |-> !sda_oe_o);
  p_step_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> $past(scl_fall_i) && $past(in_step_i));
  p_step_no_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_step_i |-> !sda_oe_o);
endmodule

bind tw_pot_cmd tw_pot_cmd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall_i(scl_fall), .stop_det_i(stop_det),
  .in_step_i(in_step), .sda_oe_o(sda_oe_o), .cmd_valid_o(cmd_valid_o),
  .cmd_op_o(cmd_op_o), .step_valid_o(step_valid_o)
);

// File: tb/tw_pot_cmd_tb.sv
`timescale 1ns/1ps
module tw_pot_cmd_tb;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap = 4'h0;
  logic sda_oe, cmd_valid, cmd_pot, step_valid, step_up;
  logic [2:0] cmd_op;
  logic [1:0] cmd_reg;
  logic [7:0] cmd_data;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int cmd_cnt = 0, up_cnt = 0, dn_cnt = 0, viol = 0;
  logic [2:0] l_op; logic l_pot; logic [1:0] l_reg; logic [7:0] l_data;
  logic prev_c = 1'b0, prev_s = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tw_pot_cmd u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .dev_addr_i(strap),
    .sda_oe_o(sda_oe), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_pot_o(cmd_pot),
    .cmd_reg_o(cmd_reg), .cmd_data_o(cmd_data), .step_valid_o(step_valid), .step_up_o(step_up)
  );

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin cmd_cnt++; l_op = cmd_op; l_pot = cmd_pot; l_reg = cmd_reg; l_data = cmd_data; end
    if (step_valid) begin if (step_up) up_cnt++; else dn_cnt++; end
    if ((cmd_valid && prev_c) || (step_valid && prev_s) || (cmd_valid && step_valid)) viol++;
    prev_c = cmd_valid; prev_s = step_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: got %0d expected %0d", req, act, exp); end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start; sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(H); endtask
  task automatic bus_stop; sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H); endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin sda_m = b[i]; w(H); scl_m = 1; w(H); scl_m = 0; end
    sda_m = 1; w(H); scl_m = 1; w(H/2); ack = sda_oe; w(H - H/2); scl_m = 0; w(H);
  endtask
  task automatic pulse(input logic d); sda_m = d; w(H); scl_m = 1; w(H); scl_m = 0; w(H); endtask

  // expected opcode classes from R5..R8: 0 none, 1 two-byte, 2 three-byte, 3 step
  function automatic int kind_of(input logic [3:0] op);
    case (op)
      4'b1101, 4'b1110, 4'b0001, 4'b1000: return 1;
      4'b1010, 4'b1100: return 2;
      4'b0010: return 3;
      default: return 0;
    endcase
  endfunction
  function automatic int code_of(input logic [3:0] op);
    case (op)
      4'b1101: return 0; 4'b1110: return 1; 4'b0001: return 2; 4'b1000: return 3;
      4'b1010: return 4; 4'b1100: return 5; default: return 7;
    endcase
  endfunction

  initial begin
    logic ack;
    int c0, u0, d0;
    w(5);
    chk(!sda_oe && !cmd_valid && !step_valid, "R1 reset outputs", {sda_oe, cmd_valid, step_valid}, 0);
    rst_n = 1; w(5);
    chk(!sda_oe && !cmd_valid && !step_valid, "R1 after reset", {sda_oe, cmd_valid, step_valid}, 0);

    // R2 / R3: address sweep against several straps
    for (int s = 0; s < 16; s += 5) begin
      strap = 4'(s);
      for (int a = 0; a < 16; a++) begin
        c0 = cmd_cnt;
        bus_start; send_byte({4'b0101, 4'(a)}, ack);
        chk(ack == (a == s), "R2 R3 address ack", ack, a == s);
        if (a != s) begin
          send_byte(8'hD0, ack);
          chk(!ack, "R3 ignored after mismatch", ack, 0);
        end
        bus_stop;
        chk(cmd_cnt == c0, "R3 no strobe", cmd_cnt - c0, 0);
      end
      bus_start; send_byte({4'b0100, 4'(s)}, ack);
      chk(!ack, "R3 wrong type nibble", ack, 0);
      bus_stop;
    end

    // opcode sweep R4..R9
    strap = 4'h9;
    for (int op = 0; op < 16; op++) begin
      for (int p = 0; p < 2; p++) begin
        logic [1:0] rg = 2'(op + p);
        logic [7:0] ins = {4'(op), 1'b0, 1'(p), rg};
        logic [7:0] dat = {4'(op), 1'(p), 3'b101} ^ 8'hA3;
        int k = kind_of(4'(op));
        c0 = cmd_cnt; u0 = up_cnt; d0 = dn_cnt;
        bus_start; send_byte(8'h59, ack);
        chk(ack, "R3 address match", ack, 1);
        send_byte(ins, ack);
        chk(ack, "R4 instruction ack", ack, 1);
        if (k == 1) begin
          send_byte(8'h55, ack);
          chk(!ack, "R9 extra byte two-byte", ack, 0);
          chk(cmd_cnt == c0, "R5 no strobe before stop", cmd_cnt - c0, 0);
          bus_stop;
          chk(cmd_cnt == c0 + 1 && l_op == 3'(code_of(4'(op))) && l_pot == 1'(p) && l_reg == rg,
              "R5 transfer strobe", {l_op, l_pot, l_reg}, {3'(code_of(4'(op))), 1'(p), rg});
        end else if (k == 2) begin
          send_byte(dat, ack);
          chk(ack, "R6 data ack", ack, 1);
          chk(cmd_cnt == c0 + 1 && l_op == 3'(code_of(4'(op))) && l_data == dat && l_pot == 1'(p) && l_reg == rg,
              "R6 write strobe", {l_op, l_data}, {3'(code_of(4'(op))), dat});
          send_byte(8'hFF, ack);
          chk(!ack, "R9 extra byte write", ack, 0);
          bus_stop;
          chk(cmd_cnt == c0 + 1, "R9 strobe count", cmd_cnt - c0, 1);
        end else if (k == 3) begin
          logic [6:0] pat = 7'(op * 19 + p * 37 + 5);
          int eu = 0;
          for (int i = 0; i < 7; i++) begin pulse(pat[i]); eu += pat[i]; end
          chk(up_cnt - u0 == eu && dn_cnt - d0 == 7 - eu, "R7 step counts", up_cnt - u0, eu);
          bus_stop; w(H);
          chk(up_cnt + dn_cnt == u0 + d0 + 7, "R7 stop gives no step", up_cnt + dn_cnt - u0 - d0, 7);
        end else begin
          send_byte(8'h00, ack);
          chk(!ack, "R8 unknown then ignored", ack, 0);
          bus_stop;
          chk(cmd_cnt == c0 && up_cnt == u0 && dn_cnt == d0, "R8 no strobe", cmd_cnt - c0, 0);
        end
      end
    end

    // R8: reserved bit set
    c0 = cmd_cnt;
    bus_start; send_byte(8'h59, ack); send_byte(8'hD9, ack);
    chk(ack, "R8 reserved-bit instruction ack", ack, 1);
    bus_stop;
    chk(cmd_cnt == c0, "R8 reserved bit no strobe", cmd_cnt - c0, 0);

    // R5: repeated start cancels a pending transfer
    bus_start; send_byte(8'h59, ack); send_byte(8'hE6, ack);
    bus_start; send_byte(8'h59, ack);
    chk(ack, "R5 readdressed after restart", ack, 1);
    bus_stop;
    chk(cmd_cnt == c0, "R5 restart discards", cmd_cnt - c0, 0);

    // R6: stop after instruction discards write
    bus_start; send_byte(8'h59, ack); send_byte(8'hA5, ack); bus_stop;
    chk(cmd_cnt == c0, "R6 stop discards write", cmd_cnt - c0, 0);

    // R7: start ends stepping, address byte clocks make no steps
    u0 = up_cnt; d0 = dn_cnt;
    bus_start; send_byte(8'h59, ack); send_byte(8'h24, ack);
    pulse(1); pulse(0);
    chk(up_cnt == u0 + 1 && dn_cnt == d0 + 1, "R7 two steps", up_cnt + dn_cnt - u0 - d0, 2);
    bus_start; send_byte(8'h59, ack);
    chk(up_cnt == u0 + 1 && dn_cnt == d0 + 1, "R7 start ends stepping", up_cnt + dn_cnt - u0 - d0, 2);
    bus_stop;

    chk(viol == 0, "R10 pulse shape", viol, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule